// File: doc/BRIEF.md
# Software Trap Interrupt Controller

This block sits next to a small 8-bit CPU core and decides which interrupt the core takes next. It has two sources of requests. The first is a non-maskable software trap. The trap fires when the all-zero opcode is loaded into the instruction register, or when a stack pop leaves the stack pointer above the selected floor. The second is a set of maskable requests, each with its own pending and enable bit, gated by a global enable. The trap is tracked by a hidden pending flag. Software cannot read or write this flag, and only reset or an explicit pending-clear strobe from the core clears it.

The block also guards instruction fetches. Any fetch address at or past the implemented memory size returns 0x00. A runaway program counter therefore ends in a trap rather than in random code.

Each accepted request produces a one-cycle acknowledge and a vector code to the core. Vector code 0 is the trap. Code i+1 is maskable source i. While the trap flag is set, or while a maskable routine is active, no maskable request is granted. A new trap is always taken.

Top module: `trap_irq_ctrl`

## Requirements
- R1: After reset, ack_o is 0 and vec_o is 0. The trap flag is clear and no maskable routine is active.
- R2: fetch_data_o equals rom_data_i when fetch_addr_i < MEM_SIZE (default 1024). Otherwise it is 0x00.
- R3: If ir_load_i is high while fetch_data_o is 0x00, the next cycle has ack_o=1 and vec_o=0, and the trap flag is set.
- R4: If pop_i is high and sp_i is strictly greater than the selected floor, a trap is taken the next cycle as in R3. The floor is 0x2F when stk_sel_i=0 and 0x6F when stk_sel_i=1. sp_i equal to the floor does not trap.
- R5: A trap is acknowledged whatever the value of gie_i.
- R6: While the trap flag is set, no maskable request is granted. The flag is cleared only by reset or by pend_clr_i, which clears it every time it is asserted. A trap event in the same cycle as pend_clr_i leaves the flag set.
- R7: A trap event while the trap flag is already set is acknowledged again with vec_o=0.
- R8: A maskable grant occurs only when gie_i=1, the trap flag is clear, no maskable routine is active, and (irq_pend_i & irq_en_i) is nonzero. The grant appears the next cycle as ack_o=1 with vec_o = lowest such index + 1.
- R9: A granted maskable routine blocks further maskable grants until reti_i is pulsed. A trap is still taken during that routine.
- R10: When a trap event and an eligible maskable request arrive in the same cycle, only the trap is acknowledged and no maskable routine starts.
- R11: When ack_o is 0, vec_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_addr_i | input | 12 | Program fetch address |
| rom_data_i | input | 8 | Raw program memory data |
| fetch_data_o | output | 8 | Guarded fetch data to the core |
| ir_load_i | input | 1 | Instruction register loads fetch_data_o this cycle |
| pop_i | input | 1 | Stack pop strobe |
| sp_i | input | 8 | Stack pointer value after the pop |
| stk_sel_i | input | 1 | Stack floor select (0: 0x2F, 1: 0x6F) |
| pend_clr_i | input | 1 | Trap pending-clear instruction strobe |
| reti_i | input | 1 | Return from maskable interrupt strobe |
| gie_i | input | 1 | Global interrupt enable |
| irq_pend_i | input | 8 | Maskable pending bits |
| irq_en_i | input | 8 | Maskable enable bits |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| vec_o | output | 4 | Vector code: 0 trap, i+1 maskable source i |

## Verification
The bench targets the stack floor boundary: sp_i at the floor must not trap, and one above it must. A design with an off-by-one compare would trap on a legal pop or miss a real over-pop. It drives a trap and a pending clear in the same cycle. A design where the clear wins would let a maskable request through on the very next cycle. It also drives a trap together with an eligible maskable request, and fetches just past the memory end. A wrong priority would start a maskable routine, and a wrong range guard would pass random opcodes instead of trapping. A long random phase then compares every cycle against a behavioural model.

// File: rtl/trap_irq_pkg.sv
package trap_irq_pkg;
  localparam logic [7:0] OP_TRAP  = 8'h00;
  localparam logic [7:0] STK_LIM0 = 8'h2F;
  localparam logic [7:0] STK_LIM1 = 8'h6F;
endpackage

// File: rtl/trap_fetch_guard.sv
module trap_fetch_guard #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int MEM_SIZE = 1024
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rom_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_SIZE);

  assign data_o = ({1'b0, addr_i} < LIMIT) ? rom_i : '0;
endmodule

// File: rtl/trap_detect.sv
module trap_detect
  import trap_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_load_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic              pop_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic              stk_sel_i,
  input  logic              clr_i,
  output logic              trap_evt_o,
  output logic              trap_pend_o
);
  logic [SP_W-1:0] floor_w;
  logic            op_hit, pop_hit, pend_q;

  assign floor_w    = stk_sel_i ? SP_W'(STK_LIM1) : SP_W'(STK_LIM0);
  assign op_hit     = ir_load_i && (opcode_i == DATA_W'(OP_TRAP));
  assign pop_hit    = pop_i && (sp_i > floor_w);
  assign trap_evt_o = op_hit || pop_hit;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (trap_evt_o) pend_q <= 1'b1;
    else if (clr_i)      pend_q <= 1'b0;
  end
  assign trap_pend_o = pend_q;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_evt_o |=> trap_pend_o);
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !trap_evt_o) |=> !trap_pend_o);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_pend_o && !clr_i) |=> trap_pend_o);
endmodule

// File: rtl/trap_mask_arb.sv
module trap_mask_arb #(
  parameter int N_SRC = 8,
  parameter int VEC_W = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             trap_evt_i,
  input  logic             trap_pend_i,
  input  logic             reti_i,
  output logic             ack_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] req;
  logic [VEC_W-1:0] sel_vec;
  logic             found, grant, isr_q, ack_q;
  logic [VEC_W-1:0] vec_q;

  assign req = pend_i & en_i;

  always_comb begin
    sel_vec = '0;
    found   = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && !found) begin
        sel_vec = VEC_W'(i + 1);
        found   = 1'b1;
      end
    end
  end

  assign grant = gie_i && found && !trap_pend_i && !isr_q && !trap_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      vec_q <= '0;
      isr_q <= 1'b0;
    end else begin
      ack_q <= trap_evt_i || grant;
      vec_q <= grant ? sel_vec : '0;
      if (grant)       isr_q <= 1'b1;
      else if (reti_i) isr_q <= 1'b0;
    end
  end

  assign ack_o = ack_q;
  assign vec_o = vec_q;

  p_trap_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_evt_i |=> (ack_o && vec_o == '0));
  p_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_pend_i |=> !(ack_o && vec_o != '0));
  p_no_nest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_q |=> !(ack_o && vec_o != '0));
  p_gie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && vec_o != '0) |-> $past(gie_i));
  p_idle_vec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> vec_o == '0);
endmodule

// File: rtl/trap_irq_ctrl.sv
module trap_irq_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int MEM_SIZE = 1024,
  parameter int SP_W     = 8,
  parameter int N_SRC    = 8,
  localparam int VEC_W   = $clog2(N_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic [DATA_W-1:0] fetch_data_o,
  input  logic              ir_load_i,
  input  logic              pop_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic              stk_sel_i,
  input  logic              pend_clr_i,
  input  logic              reti_i,
  input  logic              gie_i,
  input  logic [N_SRC-1:0]  irq_pend_i,
  input  logic [N_SRC-1:0]  irq_en_i,
  output logic              ack_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic trap_evt, trap_pend;

  trap_fetch_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_SIZE(MEM_SIZE)) u_guard (
    .addr_i (fetch_addr_i),
    .rom_i  (rom_data_i),
    .data_o (fetch_data_o)
  );

  trap_detect #(.DATA_W(DATA_W), .SP_W(SP_W)) u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ir_load_i   (ir_load_i),
    .opcode_i    (fetch_data_o),
    .pop_i       (pop_i),
    .sp_i        (sp_i),
    .stk_sel_i   (stk_sel_i),
    .clr_i       (pend_clr_i),
    .trap_evt_o  (trap_evt),
    .trap_pend_o (trap_pend)
  );

  trap_mask_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gie_i       (gie_i),
    .pend_i      (irq_pend_i),
    .en_i        (irq_en_i),
    .trap_evt_i  (trap_evt),
    .trap_pend_i (trap_pend),
    .reti_i      (reti_i),
    .ack_o       (ack_o),
    .vec_o       (vec_o)
  );

  p_trap_any_gie_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_load_i && fetch_data_o == '0) |=> (ack_o && vec_o == '0));
endmodule

// File: tb/sim_trap_irq_ctrl.sv
`timescale 1ns/1ps
module sim_trap_irq_ctrl;
  localparam int MEM = 1024;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [11:0] fetch_addr_i = '0;
  logic [7:0]  rom_data_i = 8'hFF, fetch_data_o;
  logic        ir_load_i = 0, pop_i = 0, stk_sel_i = 0, pend_clr_i = 0, reti_i = 0, gie_i = 0;
  logic [7:0]  sp_i = '0, irq_pend_i = '0, irq_en_i = '0;
  logic        ack_o;
  logic [3:0]  vec_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  bit m_flag, m_isr, m_ack;
  int m_vec;

  trap_irq_ctrl u0 (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] exp_fetch();
    return (int'(fetch_addr_i) < MEM) ? rom_data_i : 8'h00;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flag = 0; m_isr = 0; m_ack = 0; m_vec = 0;
    end else begin
      bit trap, grant;
      int lim, low;
      lim   = stk_sel_i ? 'h6F : 'h2F;
      trap  = (ir_load_i && exp_fetch() == 0) || (pop_i && int'(sp_i) > lim);
      low   = -1;
      for (int i = 7; i >= 0; i--) if (irq_pend_i[i] && irq_en_i[i]) low = i;
      grant = gie_i && !m_flag && !m_isr && low >= 0 && !trap;
      m_ack = trap || grant;
      m_vec = grant ? low + 1 : 0;
      if (trap) m_flag = 1; else if (pend_clr_i) m_flag = 0;
      if (grant) m_isr = 1; else if (reti_i) m_isr = 0;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_chk++;
      if (ack_o !== m_ack || int'(vec_o) != m_vec || fetch_data_o !== exp_fetch()) begin
        n_fail++;
        $display("FAIL %s cyc %0d: ack=%0b vec=%0d fd=%h expected ack=%0b vec=%0d fd=%h",
                 cur_req, cyc, ack_o, vec_o, fetch_data_o, m_ack, m_vec, exp_fetch());
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle();
    ir_load_i = 0; pop_i = 0; pend_clr_i = 0; reti_i = 0;
  endtask

  // apply stimulus for one cycle, then return to idle strobes
  task automatic cyc1();
    @(posedge clk_i); #5; idle();
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk_i); #5; end
  endtask

  initial begin
    #35 rst_ni = 1;
    @(posedge clk_i); #5;
    cur_req = "R1";
    wait_n(3);
    // R1 explicit: grant right after reset proves no stale flag or routine
    gie_i = 1; irq_pend_i = 8'h01; irq_en_i = 8'h01; cyc1(); irq_pend_i = 0;
    reti_i = 1; cyc1();

    cur_req = "R2";
    fetch_addr_i = 12'h100; rom_data_i = 8'hA5; wait_n(1);
    fetch_addr_i = 12'd1023; wait_n(1);
    fetch_addr_i = 12'd1024; wait_n(1);
    fetch_addr_i = 12'hFFF; wait_n(1);

    cur_req = "R3";
    fetch_addr_i = 12'h010; rom_data_i = 8'h00; ir_load_i = 1; cyc1();
    pend_clr_i = 1; cyc1();
    rom_data_i = 8'h55; ir_load_i = 1; cyc1();
    fetch_addr_i = 12'd2000; ir_load_i = 1; cyc1();   // runaway PC
    pend_clr_i = 1; cyc1();
    fetch_addr_i = 12'h010;

    cur_req = "R4";
    stk_sel_i = 0; pop_i = 1; sp_i = 8'h2F; cyc1();
    pop_i = 1; sp_i = 8'h30; cyc1();
    pend_clr_i = 1; cyc1();
    stk_sel_i = 1; pop_i = 1; sp_i = 8'h6F; cyc1();
    pop_i = 1; sp_i = 8'h30; cyc1();
    pop_i = 1; sp_i = 8'h70; cyc1();
    pend_clr_i = 1; cyc1();

    cur_req = "R5";
    gie_i = 0; rom_data_i = 8'h00; ir_load_i = 1; cyc1();

    cur_req = "R6";
    gie_i = 1; irq_pend_i = 8'h04; irq_en_i = 8'hFF; wait_n(3);
    rom_data_i = 8'h00; ir_load_i = 1; pend_clr_i = 1; cyc1();   // set beats clear
    wait_n(2);
    pend_clr_i = 1; cyc1();
    wait_n(2);
    reti_i = 1; irq_pend_i = 0; cyc1();
    pend_clr_i = 1; cyc1(); pend_clr_i = 1; cyc1();

    cur_req = "R7";
    ir_load_i = 1; cyc1(); ir_load_i = 1; cyc1(); pop_i = 1; sp_i = 8'hFF; cyc1();
    pend_clr_i = 1; cyc1();

    cur_req = "R8";
    rom_data_i = 8'h12;
    gie_i = 0; irq_pend_i = 8'hB0; irq_en_i = 8'hA0; wait_n(2);
    gie_i = 1; irq_en_i = 8'h0F; wait_n(2);
    irq_en_i = 8'hA0; cyc1();
    irq_pend_i = 0; reti_i = 1; cyc1();
    irq_pend_i = 8'h80; irq_en_i = 8'h80; cyc1();

    cur_req = "R9";
    irq_pend_i = 8'h01; irq_en_i = 8'hFF; wait_n(3);
    rom_data_i = 8'h00; ir_load_i = 1; cyc1();
    pend_clr_i = 1; cyc1();
    wait_n(1);
    reti_i = 1; cyc1();
    wait_n(1);
    reti_i = 1; irq_pend_i = 0; cyc1();

    cur_req = "R10";
    irq_pend_i = 8'h02; ir_load_i = 1; cyc1();
    wait_n(1);
    pend_clr_i = 1; cyc1();
    wait_n(1);
    reti_i = 1; irq_pend_i = 0; cyc1();

    cur_req = "R11";
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk_i); #5;
      fetch_addr_i = 12'($urandom_range(0, 1200));
      rom_data_i   = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      ir_load_i    = ($urandom_range(0, 7) == 0);
      pop_i        = ($urandom_range(0, 7) == 0);
      sp_i         = 8'($urandom_range(8'h28, 8'h74));
      stk_sel_i    = 1'($urandom);
      pend_clr_i   = ($urandom_range(0, 2) == 0);
      reti_i       = ($urandom_range(0, 3) == 0);
      gie_i        = ($urandom_range(0, 3) != 0);
      irq_pend_i   = 8'($urandom);
      irq_en_i     = 8'($urandom);
    end
    @(posedge clk_i); #5; idle();
    wait_n(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule